// File: doc/BRIEF.md
# Banked VRAM Window Address Translator

This block turns a host access that falls inside a 64K system video aperture into a linear offset into video memory of up to 1 MB. Two 8-bit bank registers set where the window sits in video memory. Each step of a bank register moves the window by 4 KB.

The block has two mapping modes. When the second window is off, the whole aperture is relocated by bank A. When the second window is on, the aperture splits into two 32K halves. The lower half adds bank B, and the upper half adds bank A. In the upper half the aperture offset keeps its 8000h weight in the sum, so the two halves translate asymmetrically. The two windows may land on the same video memory, and nothing forbids that.

The translation is captured on each access strobe. The result is held on the outputs until the next strobe, together with a flag that tells which bank register produced it. A parameter can remove the output register. The default build keeps the register.

Top module: `vram_win_xlat`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, mem_off_o is 0 and bank_sel_o is 0.
- R2: With dual_en_i low, a strobed access gives mem_off_o = (ap_off_i + bank_a_i × 1000h) mod 2^20 and bank_sel_o = 0, for every aperture offset 0000h–FFFFh.
- R3: With dual_en_i high and ap_off_i bit 15 clear (0000h–7FFFh), mem_off_o = ap_off_i + bank_b_i × 1000h and bank_sel_o = 1.
- R4: With dual_en_i high and ap_off_i bit 15 set (8000h–FFFFh), mem_off_o = ap_off_i + bank_a_i × 1000h, with the 8000h part kept in the sum, and bank_sel_o = 0. For example, bank A 0Eh and aperture 8000h give 16000h.
- R5: The sum wraps modulo 2^20. Any carry out of bit 19 is dropped. For example, bank FFh and aperture FFFFh give 0EFFFh.
- R6: The outputs take the translation of an access on the rising clock edge at which req_i is high. That is one register stage, and the result is visible in the next cycle.
- R7: While req_i is low, mem_off_o and bank_sel_o stay unchanged, whatever the aperture offset, bank and mode inputs do.
- R8: No check is made between the two bank values. Two banks that place both windows over the same video memory produce the same offset from both halves.
- R9: The 12 low bits of mem_off_o always equal the 12 low bits of the strobed aperture offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| ap_off_i | input | 16 | Offset of the access within the aperture |
| bank_a_i | input | 8 | Bank A, in 4 KB units |
| bank_b_i | input | 8 | Bank B, in 4 KB units |
| dual_en_i | input | 1 | Enables the second (split) window |
| mem_off_o | output | 20 | Translated video memory offset |
| bank_sel_o | output | 1 | Bank that was used: 0 means bank A, 1 means bank B |

## Verification
The bench sweeps aperture offsets across both halves and across every 4K boundary, crossed with bank pairs that include zero, small values, 0Eh, mid-range values, F0h and FFh, in both modes. The single-mode pass tells apart the full-aperture relocation from the split one. The dual-mode pass separates the bank B and bank A halves at 7FFFh/8000h and shows that the 8000h weight is kept. Bank values near FFh with high offsets show the modulo-2^20 wrap. Further cases cover equal targets from both windows and input changes made with no strobe, which must leave the outputs held.

// File: rtl/vram_win_pkg.sv
package vram_win_pkg;
  parameter int unsigned AP_W    = 16;
  parameter int unsigned BANK_W  = 8;
  parameter int unsigned MEM_W   = 20;
  parameter int unsigned GRAN_LG = 12;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/vram_win_sel.sv
module vram_win_sel #(
  parameter int unsigned AP_W   = 16,
  parameter int unsigned BANK_W = 8
) (
  input  logic [AP_W-1:0]   ap_off_i,
  input  logic [BANK_W-1:0] bank_a_i,
  input  logic [BANK_W-1:0] bank_b_i,
  input  logic              dual_en_i,
  output logic [BANK_W-1:0] bank_o,
  output vram_win_pkg::bank_sel_e sel_o
);
  localparam int unsigned HALF_BIT = AP_W - 1;

  logic lower_half;
  assign lower_half = ~ap_off_i[HALF_BIT];

  always_comb begin
    if (dual_en_i && lower_half) begin
      sel_o  = vram_win_pkg::BANK_B;
      bank_o = bank_b_i;
    end else begin
      sel_o  = vram_win_pkg::BANK_A;
      bank_o = bank_a_i;
    end
  end
endmodule

// File: rtl/vram_win_add.sv
module vram_win_add #(
  parameter int unsigned AP_W    = 16,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned MEM_W   = 20,
  parameter int unsigned GRAN_LG = 12
) (
  input  logic [AP_W-1:0]   ap_off_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [MEM_W-1:0]  mem_off_o
);
  localparam int unsigned SH_W = BANK_W + GRAN_LG;

  logic [SH_W-1:0]  bank_sh;
  logic [MEM_W-1:0] bank_ext;
  logic [MEM_W-1:0] ap_ext;

  // full aperture offset is added: upper half keeps its 8000h weight
  assign bank_sh   = {bank_i, {GRAN_LG{1'b0}}};
  assign bank_ext  = MEM_W'(bank_sh);
  assign ap_ext    = MEM_W'(ap_off_i);
  assign mem_off_o = ap_ext + bank_ext;
endmodule

// File: rtl/vram_win_oreg.sv
module vram_win_oreg #(
  parameter int unsigned MEM_W   = 20,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [MEM_W-1:0]        mem_off_i,
  input  vram_win_pkg::bank_sel_e sel_i,
  output logic [MEM_W-1:0]        mem_off_o,
  output vram_win_pkg::bank_sel_e sel_o
);
  if (REG_OUT) begin : g_reg
    logic [MEM_W-1:0]        off_q;
    vram_win_pkg::bank_sel_e sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q <= '0;
        sel_q <= vram_win_pkg::BANK_A;
      end else if (req_i) begin
        off_q <= mem_off_i;
        sel_q <= sel_i;
      end
    end

    assign mem_off_o = off_q;
    assign sel_o     = sel_q;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk_i ^ rst_ni ^ req_i;
    assign mem_off_o = mem_off_i;
    assign sel_o     = sel_i;
  end
endmodule

// File: rtl/vram_win_xlat.sv
module vram_win_xlat #(
  parameter int unsigned AP_W    = vram_win_pkg::AP_W,
  parameter int unsigned BANK_W  = vram_win_pkg::BANK_W,
  parameter int unsigned MEM_W   = vram_win_pkg::MEM_W,
  parameter int unsigned GRAN_LG = vram_win_pkg::GRAN_LG,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AP_W-1:0]   ap_off_i,
  input  logic [BANK_W-1:0] bank_a_i,
  input  logic [BANK_W-1:0] bank_b_i,
  input  logic              dual_en_i,
  output logic [MEM_W-1:0]  mem_off_o,
  output logic              bank_sel_o
);
  logic [BANK_W-1:0]       bank_act;
  vram_win_pkg::bank_sel_e sel_c;
  vram_win_pkg::bank_sel_e sel_r;
  logic [MEM_W-1:0]        off_c;

  vram_win_sel #(
    .AP_W  (AP_W),
    .BANK_W(BANK_W)
  ) u_sel (
    .ap_off_i (ap_off_i),
    .bank_a_i (bank_a_i),
    .bank_b_i (bank_b_i),
    .dual_en_i(dual_en_i),
    .bank_o   (bank_act),
    .sel_o    (sel_c)
  );

  vram_win_add #(
    .AP_W   (AP_W),
    .BANK_W (BANK_W),
    .MEM_W  (MEM_W),
    .GRAN_LG(GRAN_LG)
  ) u_add (
    .ap_off_i (ap_off_i),
    .bank_i   (bank_act),
    .mem_off_o(off_c)
  );

  vram_win_oreg #(
    .MEM_W  (MEM_W),
    .REG_OUT(REG_OUT)
  ) u_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .mem_off_i(off_c),
    .sel_i    (sel_c),
    .mem_off_o(mem_off_o),
    .sel_o    (sel_r)
  );

  assign bank_sel_o = (sel_r == vram_win_pkg::BANK_B);
endmodule

// File: rtl/vram_win_xlat_chk.sv
module vram_win_xlat_chk #(
  parameter int unsigned AP_W    = 16,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned MEM_W   = 20,
  parameter int unsigned GRAN_LG = 12,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [AP_W-1:0]   ap_off_i,
  input logic [BANK_W-1:0] bank_a_i,
  input logic [BANK_W-1:0] bank_b_i,
  input logic              dual_en_i,
  input logic [MEM_W-1:0]  mem_off_o,
  input logic              bank_sel_o
);
  if (REG_OUT) begin : g_chk
    AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> $stable(mem_off_o)); // R7
    AST_HOLD_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> $stable(bank_sel_o)); // R7
    AST_LOW_SEL_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && dual_en_i && !ap_off_i[AP_W-1]) |=> bank_sel_o); // R3
    AST_SEL_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && (!dual_en_i || ap_off_i[AP_W-1])) |=> !bank_sel_o); // R4
    AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> (mem_off_o[GRAN_LG-1:0] == $past(ap_off_i[GRAN_LG-1:0]))); // R9
  end else begin : g_nochk
    logic unused_ok;
    assign unused_ok = ^{clk_i, rst_ni, req_i, ap_off_i, bank_a_i, bank_b_i,
                         dual_en_i, mem_off_o, bank_sel_o};
  end
endmodule

bind vram_win_xlat vram_win_xlat_chk #(
  .AP_W   (AP_W),
  .BANK_W (BANK_W),
  .MEM_W  (MEM_W),
  .GRAN_LG(GRAN_LG),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ap_off_i  (ap_off_i),
  .bank_a_i  (bank_a_i),
  .bank_b_i  (bank_b_i),
  .dual_en_i (dual_en_i),
  .mem_off_o (mem_off_o),
  .bank_sel_o(bank_sel_o)
);

// File: tb/vram_win_xlat_tb.sv
`timescale 1ns/1ps
module vram_win_xlat_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] ap_off_i = '0;
  logic [7:0]  bank_a_i = '0;
  logic [7:0]  bank_b_i = '0;
  logic        dual_en_i = 1'b0;
  logic [19:0] mem_off_o;
  logic        bank_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vram_win_xlat u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ap_off_i  (ap_off_i),
    .bank_a_i  (bank_a_i),
    .bank_b_i  (bank_b_i),
    .dual_en_i (dual_en_i),
    .mem_off_o (mem_off_o),
    .bank_sel_o(bank_sel_o)
  );

  function automatic logic exp_sel(logic dual, logic [15:0] ap);
    return dual && !ap[15];
  endfunction

  function automatic logic [19:0] exp_off(logic dual, logic [15:0] ap,
                                          logic [7:0] ba, logic [7:0] bb);
    int unsigned b;
    b = exp_sel(dual, ap) ? bb : ba;
    return 20'((int'(ap) + b * 4096) % 1048576);
  endfunction

  task automatic chk(string rq, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%05h exp=%05h", rq, act, exp);
    end
  endtask

  task automatic access(logic dual, logic [15:0] ap, logic [7:0] ba, logic [7:0] bb);
    @(negedge clk_i);
    dual_en_i = dual; ap_off_i = ap; bank_a_i = ba; bank_b_i = bb; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic try_one(string rq, logic dual, logic [15:0] ap,
                         logic [7:0] ba, logic [7:0] bb);
    access(dual, ap, ba, bb);
    chk(rq, mem_off_o, exp_off(dual, ap, ba, bb));
    chk(rq, {19'd0, bank_sel_o}, {19'd0, exp_sel(dual, ap)});
    chk("R9", {8'd0, mem_off_o[11:0]}, {8'd0, ap[11:0]});
  endtask

  initial begin
    logic [7:0] bvals [6];
    logic [19:0] held_off;
    logic held_sel;
    bvals = '{8'h00, 8'h01, 8'h0E, 8'h5A, 8'hF0, 8'hFF};

    // R1 reset state
    #1;
    chk("R1", mem_off_o, 20'h0);
    chk("R1", {19'd0, bank_sel_o}, 20'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", mem_off_o, 20'h0);

    // R6: outputs change only at the edge where req_i is seen
    @(negedge clk_i);
    dual_en_i = 1'b0; ap_off_i = 16'h1234; bank_a_i = 8'h10; req_i = 1'b1;
    #1;
    chk("R6", mem_off_o, 20'h0);
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R6", mem_off_o, 20'h11234);

    // R4 worked example
    try_one("R4", 1'b1, 16'h8000, 8'h0E, 8'h00);
    chk("R4", mem_off_o, 20'h16000);
    // R5 wrap examples
    try_one("R5", 1'b0, 16'hFFFF, 8'hFF, 8'h00);
    chk("R5", mem_off_o, 20'h0EFFF);
    try_one("R5", 1'b1, 16'h7FFF, 8'h00, 8'hFF);
    chk("R5", mem_off_o, 20'h06FFF);
    // R3/R4 half boundary
    try_one("R3", 1'b1, 16'h7FFF, 8'h20, 8'h03);
    try_one("R4", 1'b1, 16'h8000, 8'h20, 8'h03);

    // sweep: modes x bank pairs x aperture offsets
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 34; k++) begin
            logic [15:0] ap;
            ap = (k < 32) ? 16'((k * 16'h0801) ^ (k[0] ? 16'h0FFF : 16'h0000))
                          : (k == 32 ? 16'h7FFF : 16'h8000);
            if (d == 0) try_one("R2", 1'b0, ap, bvals[i], bvals[j]);
            else if (!ap[15]) try_one("R3", 1'b1, ap, bvals[i], bvals[j]);
            else try_one("R4", 1'b1, ap, bvals[i], bvals[j]);
          end

    // R8 overlapping windows: bank A = bank B - 8 gives the same target
    for (int x = 0; x < 8; x++) begin
      logic [19:0] lo_off;
      access(1'b1, 16'(x * 16'h0F13), 8'h22, 8'h2A);
      lo_off = mem_off_o;
      access(1'b1, 16'(x * 16'h0F13) | 16'h8000, 8'h22, 8'h2A);
      chk("R8", mem_off_o, lo_off);
    end

    // R7 hold with no strobe
    try_one("R7", 1'b1, 16'h1357, 8'h44, 8'h66);
    held_off = mem_off_o;
    held_sel = bank_sel_o;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk_i);
      ap_off_i = 16'(n * 16'h1999); bank_a_i = 8'(n * 37); bank_b_i = 8'(n * 91);
      dual_en_i = n[0];
      @(negedge clk_i);
      chk("R7", mem_off_o, held_off);
      chk("R7", {19'd0, bank_sel_o}, {19'd0, held_sel});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule